// File: doc/BRIEF.md
# Register Rename and Resource Allocation Stage

This block sits between decode and the dispatch queues of an out-of-order core. It accepts at most one decoded instruction per cycle, with up to two architectural source registers and an optional architectural destination. Sources are translated through a speculative map table. A destination is given a fresh physical register taken from a FIFO free list, so later readers see the new name and no write-after-read or write-after-write conflicts are left. In the same cycle the stage reserves a reorder slot, a load or store slot for memory operations, and a place in one of two dispatch FIFOs: one for loads and stores, one for everything else. If any needed resource is missing, `in_ready` drops, and nothing at all is consumed.

Retirement comes back through a retire port. That port frees the previous physical register of the retiring destination, updates a committed copy of the map, and returns the reorder slot and any load slot. A store slot stays held until the store drains. A flush restores the speculative map from the committed copy, rewinds the free list read pointer to its committed position, clears the reorder and load counters and both queues, and sets the store counter to the number of retired stores that have not yet drained.

The control is a three-state machine. `S_INIT` loads the free list with one index per cycle and moves to `S_RUN` after its last push. `S_RUN` accepts instructions and moves to `S_FLUSH` when `flush` is seen. `S_FLUSH` holds `in_ready` low for one cycle, then returns to `S_RUN`, or stays in `S_FLUSH` while `flush` remains high.

Top module: `rn_rename_stage`

## Requirements
- R1: After reset the stage spends NUM_PHYS-NUM_ARCH cycles in `S_INIT` with `in_ready` low and both queues empty. The map starts as the identity, and the free list holds NUM_ARCH..NUM_PHYS-1 in ascending order.
- R2: Each source is renamed to the physical register assigned by the most recent earlier accepted writer of that architectural register, including the instruction immediately before.
- R3: An accepted instruction with a destination takes the free-list head as its new register and reports the replaced mapping as `prev`. An instruction without a destination takes no register, and its dst and prev fields are zero.
- R4: Loads and stores (`in_is_load` or `in_is_store` set) enter the memory queue; all other instructions enter the ALU queue. Entry layout, MSB first, is: dst_valid (1 bit), dst, prev, src1, src2 (PW bits each), is_store (bit 0).
- R5: An instruction that needs a destination is refused while the free list is empty. One without a destination is still accepted.
- R6: A load is refused while LOAD_SLOTS loads are held, and a store is refused while STORE_SLOTS stores are held.
- R7: Any instruction is refused while ROB_SLOTS reorder slots are held.
- R8: An instruction is refused while its target queue holds QDEPTH entries.
- R9: A refused instruction consumes nothing, and each queue delivers its entries in program order.
- R10: A retire returns a reorder slot, a load slot if `ret_is_load` is set, and `ret_old_phys` to the free-list tail if `ret_has_dst` is set. A retired store keeps its slot until a `st_drain` pulse.
- R11: A flush restores the committed map and the committed free-list position, empties both queues, zeroes the reorder and load counts, sets the store count to the retired-but-undrained stores, and holds `in_ready` low for the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Decoded instruction present |
| in_dst_valid | input | 1 | Instruction writes a destination |
| in_dst_arch | input | AW | Architectural destination |
| in_src1_arch | input | AW | First architectural source |
| in_src2_arch | input | AW | Second architectural source |
| in_is_load | input | 1 | Instruction is a load |
| in_is_store | input | 1 | Instruction is a store |
| in_ready | output | 1 | All needed resources available; accept this cycle |
| ret_valid | input | 1 | One instruction retires |
| ret_has_dst | input | 1 | Retiring instruction wrote a destination |
| ret_arch | input | AW | Its architectural destination |
| ret_new_phys | input | PW | Its physical destination, now committed |
| ret_old_phys | input | PW | Previous mapping, returned to the free list |
| ret_is_load | input | 1 | Retiring instruction is a load |
| ret_is_store | input | 1 | Retiring instruction is a store |
| st_drain | input | 1 | One retired store has left the store buffer |
| flush | input | 1 | Discard all unretired work |
| alu_q_valid | output | 1 | ALU queue head valid |
| alu_q_data | output | ENTRY_W | ALU queue head entry |
| alu_q_pop | input | 1 | Remove ALU queue head |
| mem_q_valid | output | 1 | Memory queue head valid |
| mem_q_data | output | ENTRY_W | Memory queue head entry |
| mem_q_pop | input | 1 | Remove memory queue head |

## Verification
`in_ready` is combinational on the current counters and the offered instruction. The bench drives an instruction at a falling edge and samples `in_ready` 1 ns later in the same cycle. An accepted entry is written at the next rising edge, so the queue head is checked at the falling edge that follows. Retire, drain and flush act at the next rising edge. Their effect is observed one cycle later through whether a following offer is accepted, and through the names that offer receives. After a flush, the `S_FLUSH` cycle is checked for low `in_ready` at the first falling edge, and the restored state is checked with the offer made at the second.

// File: rtl/rn_pkg.sv
package rn_pkg;
    typedef enum logic [1:0] {
        S_INIT  = 2'd0,
        S_RUN   = 2'd1,
        S_FLUSH = 2'd2
    } rn_state_e;
endpackage

// File: rtl/rn_fifo.sv
module rn_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic         clear,
    input  logic [W-1:0] din,
    output logic         valid,
    output logic         full,
    output logic [W-1:0] dout
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [IW-1:0] rd_q, wr_q;
    logic [CW-1:0] cnt_q;
    logic          do_push, do_pop;

    assign full    = (cnt_q == CW'(DEPTH));
    assign valid   = (cnt_q != '0);
    assign do_push = push && !full;
    assign do_pop  = pop && valid;
    assign dout    = mem[rd_q];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else if (clear) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wr_q <= (wr_q == IW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
            if (do_pop)  rd_q <= (rd_q == IW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
            cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !clear) mem[wr_q] <= din;
    end
endmodule

// File: rtl/rn_credit.sv
module rn_credit #(
    parameter int MAX = 8,
    parameter int CW  = $clog2(MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          dec,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic [CW-1:0] count,
    output logic          full
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt_q <= '0;
        else if (load) cnt_q <= load_val;
        else           cnt_q <= cnt_q + CW'(inc) - CW'(dec);
    end

    assign count = cnt_q;
    assign full  = (cnt_q == CW'(MAX));
endmodule

// File: rtl/rn_free_list.sv
module rn_free_list #(
    parameter int PW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [PW-1:0] push_idx,
    input  logic          pop,
    input  logic          commit_adv,
    input  logic          restore,
    output logic [PW-1:0] head_idx,
    output logic [PW:0]   count
);
    localparam int DEPTH = 1 << PW;

    logic [PW-1:0] mem [DEPTH];
    logic [PW:0]   head_q, tail_q, chead_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head_q  <= '0;
            tail_q  <= '0;
            chead_q <= '0;
        end else begin
            if (push)         tail_q  <= tail_q + 1'b1;
            if (restore)      head_q  <= chead_q;
            else if (pop)     head_q  <= head_q + 1'b1;
            if (commit_adv)   chead_q <= chead_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[tail_q[PW-1:0]] <= push_idx;
    end

    assign head_idx = mem[head_q[PW-1:0]];
    assign count    = tail_q - head_q;
endmodule

// File: rtl/rn_map_table.sv
module rn_map_table #(
    parameter int NUM_ARCH = 32,
    parameter int AW       = 5,
    parameter int PW       = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd1_arch,
    input  logic [AW-1:0] rd2_arch,
    input  logic [AW-1:0] rd3_arch,
    output logic [PW-1:0] rd1_phys,
    output logic [PW-1:0] rd2_phys,
    output logic [PW-1:0] rd3_phys,
    input  logic          spec_we,
    input  logic [AW-1:0] spec_arch,
    input  logic [PW-1:0] spec_phys,
    input  logic          cmt_we,
    input  logic [AW-1:0] cmt_arch,
    input  logic [PW-1:0] cmt_phys,
    input  logic          restore
);
    logic [PW-1:0] spec_q [NUM_ARCH];
    logic [PW-1:0] cmt_q  [NUM_ARCH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_ARCH; i++) spec_q[i] <= PW'(i);
        end else if (restore) begin
            for (int i = 0; i < NUM_ARCH; i++) spec_q[i] <= cmt_q[i];
        end else if (spec_we) begin
            spec_q[spec_arch] <= spec_phys;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_ARCH; i++) cmt_q[i] <= PW'(i);
        end else if (cmt_we) begin
            cmt_q[cmt_arch] <= cmt_phys;
        end
    end

    assign rd1_phys = spec_q[rd1_arch];
    assign rd2_phys = spec_q[rd2_arch];
    assign rd3_phys = spec_q[rd3_arch];
endmodule

// File: rtl/rn_rename_stage.sv
module rn_rename_stage
    import rn_pkg::*;
#(
    parameter int NUM_ARCH    = 32,
    parameter int NUM_PHYS    = 128,
    parameter int ROB_SLOTS   = 64,
    parameter int LOAD_SLOTS  = 48,
    parameter int STORE_SLOTS = 24,
    parameter int QDEPTH      = 8,
    localparam int AW      = $clog2(NUM_ARCH),
    localparam int PW      = $clog2(NUM_PHYS),
    localparam int ENTRY_W = 2 + 4 * PW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               in_dst_valid,
    input  logic [AW-1:0]      in_dst_arch,
    input  logic [AW-1:0]      in_src1_arch,
    input  logic [AW-1:0]      in_src2_arch,
    input  logic               in_is_load,
    input  logic               in_is_store,
    output logic               in_ready,
    input  logic               ret_valid,
    input  logic               ret_has_dst,
    input  logic [AW-1:0]      ret_arch,
    input  logic [PW-1:0]      ret_new_phys,
    input  logic [PW-1:0]      ret_old_phys,
    input  logic               ret_is_load,
    input  logic               ret_is_store,
    input  logic               st_drain,
    input  logic               flush,
    output logic               alu_q_valid,
    output logic [ENTRY_W-1:0] alu_q_data,
    input  logic               alu_q_pop,
    output logic               mem_q_valid,
    output logic [ENTRY_W-1:0] mem_q_data,
    input  logic               mem_q_pop
);
    localparam int INIT_N = NUM_PHYS - NUM_ARCH;
    localparam int ICW    = $clog2(INIT_N + 1);
    localparam int RW     = $clog2(ROB_SLOTS + 1);
    localparam int LW     = $clog2(LOAD_SLOTS + 1);
    localparam int SW     = $clog2(STORE_SLOTS + 1);

    rn_state_e state_q, state_d;
    logic [ICW-1:0] init_cnt_q;
    logic init_push, accept_en;

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= S_INIT;
            init_cnt_q <= '0;
        end else begin
            state_q <= state_d;
            if (init_push) init_cnt_q <= init_cnt_q + 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_INIT:  if (init_cnt_q == ICW'(INIT_N - 1)) state_d = S_RUN;
            S_RUN:   if (flush) state_d = S_FLUSH;
            S_FLUSH: state_d = flush ? S_FLUSH : S_RUN;
            default: state_d = S_INIT;
        endcase
    end

    // ---------------- state outputs ----------------
    always_comb begin
        init_push = 1'b0;
        accept_en = 1'b0;
        unique case (state_q)
            S_INIT:  init_push = 1'b1;
            S_RUN:   accept_en = 1'b1;
            S_FLUSH: accept_en = 1'b0;
            default: accept_en = 1'b0;
        endcase
    end

    // ---------------- resource checks ----------------
    logic          is_mem, fire, do_flush, ret_fire, drain_fire;
    logic [PW:0]   free_cnt;
    logic [PW-1:0] free_head;
    logic [RW-1:0] rob_cnt;
    logic [LW-1:0] ld_cnt;
    logic [SW-1:0] st_cnt, st_cmt_cnt;
    logic          rob_full, ld_full, st_full, st_cmt_full;
    logic          q_full [2];
    logic          q_push [2];
    logic          q_pop  [2];
    logic          q_valid[2];
    logic [ENTRY_W-1:0] q_dout [2];
    logic          reg_ok, ld_ok, st_ok, q_ok;

    assign is_mem     = in_is_load || in_is_store;
    assign do_flush   = flush && (state_q != S_INIT);
    assign ret_fire   = ret_valid && (state_q != S_INIT) && !flush;
    assign drain_fire = st_drain && (state_q != S_INIT) && (st_cmt_cnt != '0);

    assign reg_ok = !in_dst_valid || (free_cnt != '0);
    assign ld_ok  = !in_is_load   || !ld_full;
    assign st_ok  = !in_is_store  || !st_full;
    assign q_ok   = is_mem ? !q_full[1] : !q_full[0];

    assign in_ready = accept_en && !flush && reg_ok && ld_ok && st_ok && q_ok && !rob_full;
    assign fire     = in_valid && in_ready;

    // ---------------- free list and map ----------------
    logic [PW-1:0] fl_push_idx, src1_phys, src2_phys, prev_phys;
    logic          fl_push;

    assign fl_push     = init_push || (ret_fire && ret_has_dst);
    assign fl_push_idx = init_push ? (PW'(NUM_ARCH) + PW'(init_cnt_q)) : ret_old_phys;

    rn_free_list #(.PW(PW)) u_free (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (fl_push),
        .push_idx   (fl_push_idx),
        .pop        (fire && in_dst_valid),
        .commit_adv (ret_fire && ret_has_dst),
        .restore    (do_flush),
        .head_idx   (free_head),
        .count      (free_cnt)
    );

    rn_map_table #(.NUM_ARCH(NUM_ARCH), .AW(AW), .PW(PW)) u_map (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd1_arch  (in_src1_arch),
        .rd2_arch  (in_src2_arch),
        .rd3_arch  (in_dst_arch),
        .rd1_phys  (src1_phys),
        .rd2_phys  (src2_phys),
        .rd3_phys  (prev_phys),
        .spec_we   (fire && in_dst_valid),
        .spec_arch (in_dst_arch),
        .spec_phys (free_head),
        .cmt_we    (ret_fire && ret_has_dst),
        .cmt_arch  (ret_arch),
        .cmt_phys  (ret_new_phys),
        .restore   (do_flush)
    );

    // ---------------- slot counters ----------------
    rn_credit #(.MAX(ROB_SLOTS), .CW(RW)) u_rob (
        .clk(clk), .rst_n(rst_n), .inc(fire), .dec(ret_fire),
        .load(do_flush), .load_val('0), .count(rob_cnt), .full(rob_full)
    );

    rn_credit #(.MAX(LOAD_SLOTS), .CW(LW)) u_ld (
        .clk(clk), .rst_n(rst_n), .inc(fire && in_is_load), .dec(ret_fire && ret_is_load),
        .load(do_flush), .load_val('0), .count(ld_cnt), .full(ld_full)
    );

    rn_credit #(.MAX(STORE_SLOTS), .CW(SW)) u_st (
        .clk(clk), .rst_n(rst_n), .inc(fire && in_is_store), .dec(drain_fire),
        .load(do_flush), .load_val(st_cmt_cnt - SW'(drain_fire)),
        .count(st_cnt), .full(st_full)
    );

    rn_credit #(.MAX(STORE_SLOTS), .CW(SW)) u_st_cmt (
        .clk(clk), .rst_n(rst_n), .inc(ret_fire && ret_is_store), .dec(drain_fire),
        .load(1'b0), .load_val('0), .count(st_cmt_cnt), .full(st_cmt_full)
    );

    // ---------------- dispatch queues: 0 = ALU, 1 = memory ----------------
    logic [ENTRY_W-1:0] entry;
    assign entry = {in_dst_valid,
                    in_dst_valid ? free_head : '0,
                    in_dst_valid ? prev_phys : '0,
                    src1_phys, src2_phys, in_is_store};

    assign q_push[0] = fire && !is_mem;
    assign q_push[1] = fire && is_mem;
    assign q_pop[0]  = alu_q_pop;
    assign q_pop[1]  = mem_q_pop;

    for (genvar g = 0; g < 2; g++) begin : g_queue
        rn_fifo #(.DEPTH(QDEPTH), .W(ENTRY_W)) u_q (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (q_push[g]),
            .pop   (q_pop[g]),
            .clear (do_flush),
            .din   (entry),
            .valid (q_valid[g]),
            .full  (q_full[g]),
            .dout  (q_dout[g])
        );
    end

    assign alu_q_valid = q_valid[0];
    assign alu_q_data  = q_dout[0];
    assign mem_q_valid = q_valid[1];
    assign mem_q_data  = q_dout[1];
endmodule

// File: rtl/rn_rename_chk.sv
module rn_rename_chk
    import rn_pkg::*;
#(
    parameter int FW = 8,
    parameter int RW = 7,
    parameter int LW = 6,
    parameter int SW = 5,
    parameter int ROB_SLOTS   = 64,
    parameter int LOAD_SLOTS  = 48,
    parameter int STORE_SLOTS = 24
) (
    input logic          clk,
    input logic          rst_n,
    input rn_state_e     state_q,
    input logic          in_valid,
    input logic          in_ready,
    input logic          in_dst_valid,
    input logic          in_is_load,
    input logic          in_is_store,
    input logic          flush,
    input logic          alu_q_valid,
    input logic          mem_q_valid,
    input logic [FW-1:0] free_cnt,
    input logic [RW-1:0] rob_cnt,
    input logic [LW-1:0] ld_cnt,
    input logic [SW-1:0] st_cnt
);
    a_r1_init_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_INIT) |-> !in_ready);

    a_r5_no_reg_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (in_dst_valid && free_cnt == '0) |-> !in_ready);

    a_r7_rob_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        rob_cnt <= RW'(ROB_SLOTS));

    a_r6_ld_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        ld_cnt <= LW'(LOAD_SLOTS));

    a_r6_st_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        st_cnt <= SW'(STORE_SLOTS));

    a_r4_alu_steer: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !in_is_load && !in_is_store && !flush) |=> alu_q_valid);

    a_r4_mem_steer: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && (in_is_load || in_is_store) && !flush) |=> mem_q_valid);

    a_r11_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && state_q != S_INIT) |=> (!alu_q_valid && !mem_q_valid && !in_ready));
endmodule

bind rn_rename_stage rn_rename_chk #(
    .FW(PW + 1), .RW(RW), .LW(LW), .SW(SW),
    .ROB_SLOTS(ROB_SLOTS), .LOAD_SLOTS(LOAD_SLOTS), .STORE_SLOTS(STORE_SLOTS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .state_q     (state_q),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_dst_valid(in_dst_valid),
    .in_is_load  (in_is_load),
    .in_is_store (in_is_store),
    .flush       (flush),
    .alu_q_valid (alu_q_valid),
    .mem_q_valid (mem_q_valid),
    .free_cnt    (free_cnt),
    .rob_cnt     (rob_cnt),
    .ld_cnt      (ld_cnt),
    .st_cnt      (st_cnt)
);

// File: tb/rn_rename_stage_tb.sv
`timescale 1ns/1ps
module rn_rename_stage_tb;
    localparam int NA = 32, NP = 40, AWB = 5, PWB = 6, EW = 26;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n = 1'b0;
    logic in_valid = 0, in_dst_valid = 0, in_is_load = 0, in_is_store = 0, in_ready;
    logic [AWB-1:0] in_dst_arch = '0, in_src1_arch = '0, in_src2_arch = '0;
    logic ret_valid = 0, ret_has_dst = 0, ret_is_load = 0, ret_is_store = 0;
    logic [AWB-1:0] ret_arch = '0;
    logic [PWB-1:0] ret_new_phys = '0, ret_old_phys = '0;
    logic st_drain = 0, flush = 0;
    logic alu_q_valid, mem_q_valid, alu_q_pop = 0, mem_q_pop = 0;
    logic [EW-1:0] alu_q_data, mem_q_data;

    rn_rename_stage #(.NUM_ARCH(NA), .NUM_PHYS(NP), .ROB_SLOTS(16),
        .LOAD_SLOTS(2), .STORE_SLOTS(2), .QDEPTH(4)) u_dut (.*);

    int checks = 0, errors = 0;

    typedef struct packed {
        logic dv; logic [4:0] da, s1, s2; logic ld, st;
        logic [5:0] edst, eprev, es1, es2;
    } vec_t;

    localparam vec_t VEC [7] = '{
        '{1'b1, 5'd1, 5'd2, 5'd3, 1'b0, 1'b0, 6'd32, 6'd1,  6'd2,  6'd3},
        '{1'b1, 5'd4, 5'd1, 5'd1, 1'b0, 1'b0, 6'd33, 6'd4,  6'd32, 6'd32},
        '{1'b1, 5'd1, 5'd5, 5'd4, 1'b0, 1'b0, 6'd34, 6'd32, 6'd5,  6'd33},
        '{1'b0, 5'd0, 5'd1, 5'd7, 1'b0, 1'b0, 6'd0,  6'd0,  6'd34, 6'd7},
        '{1'b1, 5'd7, 5'd1, 5'd4, 1'b0, 1'b0, 6'd35, 6'd7,  6'd34, 6'd33},
        '{1'b1, 5'd2, 5'd4, 5'd0, 1'b1, 1'b0, 6'd36, 6'd2,  6'd33, 6'd0},
        '{1'b0, 5'd0, 5'd2, 5'd7, 1'b0, 1'b1, 6'd0,  6'd0,  6'd36, 6'd35}
    };

    function automatic logic [EW-1:0] ent(input logic dv, input logic [5:0] d, p, a, b,
                                          input logic st);
        return {dv, d, p, a, b, st};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic offer(input logic dv, input logic [4:0] da, s1, s2,
                         input logic ld, st, output logic rdy);
        in_valid = 1; in_dst_valid = dv; in_dst_arch = da;
        in_src1_arch = s1; in_src2_arch = s2; in_is_load = ld; in_is_store = st;
        #1 rdy = in_ready;
        @(negedge clk);
        in_valid = 0; in_dst_valid = 0; in_is_load = 0; in_is_store = 0;
    endtask

    task automatic head(input bit m, input logic [EW-1:0] exp, input string req);
        logic v; logic [EW-1:0] d;
        v = m ? mem_q_valid : alu_q_valid;
        d = m ? mem_q_data  : alu_q_data;
        chk(v && d == exp, req, {5'd0, v, d}, {5'd0, 1'b1, exp});
    endtask

    task automatic pop(input bit m);
        if (m) mem_q_pop = 1; else alu_q_pop = 1;
        @(negedge clk);
        mem_q_pop = 0; alu_q_pop = 0;
    endtask

    task automatic retire(input logic has, input logic [4:0] a, input logic [5:0] np, op,
                          input logic ld, st);
        ret_valid = 1; ret_has_dst = has; ret_arch = a; ret_new_phys = np;
        ret_old_phys = op; ret_is_load = ld; ret_is_store = st;
        @(negedge clk);
        ret_valid = 0; ret_has_dst = 0; ret_is_load = 0; ret_is_store = 0;
    endtask

    task automatic do_flush();
        flush = 1;
        @(negedge clk);
        flush = 0;
        #1;
        chk(!in_ready, "R11 ready low in recovery", in_ready, 0);
        chk(!alu_q_valid && !mem_q_valid, "R11 queues emptied",
            {alu_q_valid, mem_q_valid}, 0);
        @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic rdy;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1: init window of NP-NA cycles
        for (int k = 1; k <= 8; k++) begin
            @(negedge clk);
            if (k == 1) chk(!in_ready && !alu_q_valid && !mem_q_valid, "R1 reset state",
                            {in_ready, alu_q_valid, mem_q_valid}, 0);
            if (k == 7) chk(!in_ready, "R1 still initialising", in_ready, 0);
            if (k == 8) chk(in_ready, "R1 ready after init", in_ready, 1);
        end

        // R2 R3 R4 vector table
        for (int i = 0; i < 7; i++) begin
            offer(VEC[i].dv, VEC[i].da, VEC[i].s1, VEC[i].s2, VEC[i].ld, VEC[i].st, rdy);
            chk(rdy, "R9 vector accepted", rdy, 1);
            head(VEC[i].ld || VEC[i].st,
                 ent(VEC[i].dv, VEC[i].edst, VEC[i].eprev, VEC[i].es1, VEC[i].es2, VEC[i].st),
                 "R2 R3 R4 vector entry");
            pop(VEC[i].ld || VEC[i].st);
        end

        // R5 free register exhaustion
        offer(1, 10, 1, 2, 0, 0, rdy); head(0, ent(1, 37, 10, 34, 36, 0), "R3 r10"); pop(0);
        offer(1, 11, 10, 0, 0, 0, rdy); head(0, ent(1, 38, 11, 37, 0, 0), "R2 r11"); pop(0);
        offer(1, 12, 11, 11, 0, 0, rdy); head(0, ent(1, 39, 12, 38, 38, 0), "R2 r12"); pop(0);
        offer(1, 13, 0, 0, 0, 0, rdy);
        chk(!rdy, "R5 refused with empty free list", rdy, 0);
        chk(!alu_q_valid, "R9 refused consumes nothing", alu_q_valid, 0);
        offer(0, 0, 12, 3, 0, 0, rdy);
        chk(rdy, "R5 no-destination still accepted", rdy, 1);
        head(0, ent(0, 0, 0, 39, 3, 0), "R3 no-destination fields"); pop(0);

        // R10 in-order retirement
        retire(1, 1, 32, 1, 0, 0);
        retire(1, 4, 33, 4, 0, 0);

        // R6 load slots
        offer(1, 13, 4, 0, 1, 0, rdy); head(1, ent(1, 1, 13, 33, 0, 0), "R10 freed reg reused"); pop(1);
        offer(1, 14, 0, 0, 1, 0, rdy);
        chk(!rdy, "R6 load slots full", rdy, 0);
        chk(!mem_q_valid, "R9 refused load consumes nothing", mem_q_valid, 0);
        retire(1, 1, 34, 32, 0, 0);
        retire(0, 0, 0, 0, 0, 0);
        retire(1, 7, 35, 7, 0, 0);
        retire(1, 2, 36, 2, 1, 0);
        offer(1, 14, 0, 0, 1, 0, rdy);
        chk(rdy, "R10 load slot returned", rdy, 1);
        head(1, ent(1, 4, 14, 0, 0, 0), "R10 freed reg order"); pop(1);
        offer(0, 0, 13, 12, 0, 1, rdy); head(1, ent(0, 0, 0, 1, 39, 1), "R4 store entry"); pop(1);
        offer(0, 0, 0, 0, 0, 1, rdy);
        chk(!rdy, "R6 store slots full", rdy, 0);

        // R8 queue full, R9 order
        for (int k = 0; k < 4; k++) offer(0, 0, 5'(20 + k), 0, 0, 0, rdy);
        offer(0, 0, 0, 0, 0, 0, rdy);
        chk(!rdy, "R8 ALU queue full", rdy, 0);
        for (int k = 0; k < 4; k++) begin
            head(0, ent(0, 0, 0, 6'(20 + k), 0, 0), "R9 queue order");
            pop(0);
        end

        // R7 reorder slots: 12 held, fill to 16
        for (int k = 0; k < 4; k++) begin offer(0, 0, 0, 0, 0, 0, rdy); pop(0); end
        offer(0, 0, 0, 0, 0, 0, rdy);
        chk(!rdy, "R7 reorder slots full", rdy, 0);

        // R11 flush restores committed map and free position
        do_flush();
        offer(1, 5, 1, 4, 0, 0, rdy);
        head(0, ent(1, 37, 5, 34, 33, 0), "R11 restored map and free list"); pop(0);
        offer(1, 6, 2, 0, 1, 0, rdy);
        head(1, ent(1, 38, 6, 36, 0, 0), "R11 load count cleared"); pop(1);
        offer(1, 8, 7, 0, 1, 0, rdy);
        chk(rdy, "R11 second load accepted", rdy, 1);
        head(1, ent(1, 39, 8, 35, 0, 0), "R11 committed r7"); pop(1);

        // R11 store count restored to undrained retired stores, R10 drain
        offer(0, 0, 0, 0, 0, 1, rdy); pop(1);
        retire(1, 5, 37, 5, 0, 0);
        retire(1, 6, 38, 6, 1, 0);
        retire(1, 8, 39, 8, 1, 0);
        retire(0, 0, 0, 0, 0, 1);
        do_flush();
        offer(0, 0, 0, 0, 0, 1, rdy);
        chk(rdy, "R11 one store slot free", rdy, 1); pop(1);
        offer(0, 0, 0, 0, 0, 1, rdy);
        chk(!rdy, "R11 retired store keeps slot", rdy, 0);
        st_drain = 1; @(negedge clk); st_drain = 0;
        offer(0, 0, 0, 0, 0, 1, rdy);
        chk(rdy, "R10 drain returns store slot", rdy, 1); pop(1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule